// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This block sits between a simple request port and an asynchronous DRAM device whose address pins are half as wide as the word address. For each request it puts the upper half of the address (the row) on the shared pins and drops the row strobe. It then puts the lower half (the column) on the same pins and drops the column strobe. Both strobes are active low. Write data and the write-enable line are driven before the column strobe falls. Read data is sampled a set number of clock cycles after the column strobe falls and is returned with a one-cycle valid pulse.

After an access the row stays open. A following request to the same row is a page hit: it issues only a new column cycle. A request to a different row first precharges the open row and then opens the new one. A free-running interval timer raises a refresh request on a fixed period. The controller serves it with a row-only strobe cycle, using an internal row counter. Refresh waits for the current access to end, closes any open page, and runs before any new request is accepted. All strobe timings are parameters counted in clock cycles.

Top module: `dram_ctrl`

## Requirements
- R1: After reset both strobes and the write-enable are high, the data-out enable is low, no response is valid, and `req_ready` is high.
- R2: When the row strobe falls, the pins carry address bits [ADDR_W-1:ADDR_W/2] of the request, and the pins do not change on that edge.
- R3: When the column strobe falls, the pins carry address bits [ADDR_W/2-1:0], the pins are stable on that edge, and the column strobe is low only while the row strobe is low.
- R4: On a freshly opened row the column strobe falls T_RCD+1 cycles after the row strobe. Every column strobe pulse lasts exactly T_CAS cycles. The row strobe stays high for at least T_RP cycles before it falls again.
- R5: For a write, `mem_we_n` is low and `mem_dq_oe` is high with the write data from at least one cycle before the column strobe falls until it rises. The value written is `req_wdata`.
- R6: For a read, `rsp_valid` pulses once and `rsp_rdata` equals the device data sampled RD_LAT cycles after the column strobe fell. A read after a write to the same address returns the written value.
- R7: A request whose row equals the open row causes no row strobe fall.
- R8: A request to another row (or with no row open) causes exactly one row strobe fall for that access, after a precharge when a row was open.
- R9: Refresh is a row-strobe-only cycle lasting T_RAS cycles. Refresh cycles use rows 0, 1, 2, ... wrapping at 2^(ADDR_W/2). Consecutive refreshes start no more than REF_INTERVAL+16 cycles apart, even under continuous traffic.
- R10: While a refresh is pending, `req_ready` is low. An open page is precharged before the refresh, so the next access after a refresh reopens its row.
- R11: `req_ready` is low from the cycle after a request is accepted until the access has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Full word address, row in upper half |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W/2 | Multiplexed row/column address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data driven to the device |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the device |

## Verification
The bench writes every address in row order, mostly page hits, and reads it all back in column order, so every read is a row miss. A design that swapped the address halves, or held the column on the pins at the row strobe, would return the wrong words. A dedicated miss/hit/miss sequence counts row strobe edges, which catches a controller that reopens on a hit or skips the precharge on a miss. A long run of back-to-back hits checks that refresh still breaks in on time with sequential rows. It also checks that the page is reopened afterwards; a controller that starved refresh or left the row open through it fails there.

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_RAS        = 3,
  parameter int RD_LAT       = 2,
  parameter int REF_INTERVAL = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W/2-1:0] mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int HALF     = ADDR_W / 2;
  localparam int CW       = 8;
  localparam int RCW      = $clog2(REF_INTERVAL);
  localparam int MAX_WAIT = 2 * T_RP + T_RCD + T_CAS + 4;

  typedef enum logic [3:0] {
    S_IDLE, S_ROW, S_RCD, S_COL, S_CAS, S_OPEN, S_PRE, S_RFROW, S_RFRAS
  } st_t;

  st_t state, nstate;
  logic [CW-1:0]     cnt, ncnt;
  logic              have_req, n_have;
  logic [ADDR_W-1:0] q_addr, n_addr;
  logic              q_we, n_we;
  logic [DATA_W-1:0] q_wdata, n_wdata;
  logic [HALF-1:0]   open_row, ref_row;
  logic [RCW-1:0]    ref_cnt;
  logic              ref_pend;

  wire accept = req_valid & req_ready;
  wire hit    = req_addr[ADDR_W-1:HALF] == open_row;
  wire wr_ph  = (nstate == S_COL || nstate == S_CAS) && n_we;
  wire row_lo = nstate inside {S_RCD, S_COL, S_CAS, S_OPEN, S_RFRAS};

  assign req_ready = (state == S_IDLE || state == S_OPEN) && !ref_pend;
  assign n_addr    = accept ? req_addr  : q_addr;
  assign n_we      = accept ? req_write : q_we;
  assign n_wdata   = accept ? req_wdata : q_wdata;

  always_comb begin
    nstate = state;
    ncnt   = (cnt != '0) ? cnt - 1'b1 : '0;
    n_have = have_req;
    case (state)
      S_IDLE:  if (ref_pend) nstate = S_RFROW;
               else if (accept) nstate = S_ROW;
      S_ROW:   begin nstate = S_RCD; ncnt = CW'(T_RCD - 1); n_have = 1'b0; end
      S_RCD:   if (cnt == '0) nstate = S_COL;
      S_COL:   begin nstate = S_CAS; ncnt = CW'(T_CAS - 1); end
      S_CAS:   if (cnt == '0) nstate = S_OPEN;
      S_OPEN:  if (ref_pend) begin
                 nstate = S_PRE; ncnt = CW'(T_RP - 1);
               end else if (accept) begin
                 if (hit) nstate = S_COL;
                 else begin nstate = S_PRE; ncnt = CW'(T_RP - 1); n_have = 1'b1; end
               end
      S_PRE:   if (cnt == '0) begin
                 if (have_req) nstate = S_ROW;
                 else if (ref_pend) nstate = S_RFROW;
                 else nstate = S_IDLE;
               end
      S_RFROW: begin nstate = S_RFRAS; ncnt = CW'(T_RAS - 1); end
      S_RFRAS: if (cnt == '0) begin nstate = S_PRE; ncnt = CW'(T_RP - 1); end
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; have_req <= 1'b0;
      q_addr <= '0; q_we <= 1'b0; q_wdata <= '0; open_row <= '0;
    end else begin
      state <= nstate; cnt <= ncnt; have_req <= n_have;
      if (accept) begin q_addr <= req_addr; q_we <= req_write; q_wdata <= req_wdata; end
      if (state == S_ROW) open_row <= q_addr[ADDR_W-1:HALF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0; ref_pend <= 1'b0; ref_row <= '0;
    end else begin
      ref_cnt <= (ref_cnt == RCW'(REF_INTERVAL - 1)) ? '0 : ref_cnt + 1'b1;
      if (ref_cnt == RCW'(REF_INTERVAL - 1)) ref_pend <= 1'b1;
      else if (nstate == S_RFROW) ref_pend <= 1'b0;
      if (state == S_RFRAS && nstate == S_PRE) ref_row <= ref_row + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ras_n <= 1'b1; mem_cas_n <= 1'b1; mem_we_n <= 1'b1; mem_dq_oe <= 1'b0;
      mem_dq_out <= '0; mem_addr <= '0; rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      mem_ras_n  <= !row_lo;
      mem_cas_n  <= nstate != S_CAS;
      mem_we_n   <= !wr_ph;
      mem_dq_oe  <= wr_ph;
      mem_dq_out <= n_wdata;
      case (nstate)
        S_ROW, S_RCD:     mem_addr <= n_addr[ADDR_W-1:HALF];
        S_COL, S_CAS:     mem_addr <= n_addr[HALF-1:0];
        S_RFROW, S_RFRAS: mem_addr <= ref_row;
        default:          mem_addr <= mem_addr;
      endcase
      rsp_valid <= state == S_CAS && cnt == CW'(T_CAS - RD_LAT) && !q_we;
      if (state == S_CAS && cnt == CW'(T_CAS - RD_LAT) && !q_we) rsp_rdata <= mem_dq_in;
    end
  end

  logic [CW-1:0] hi_cnt, ref_wait;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= CW'(T_RP); ref_wait <= '0;
    end else begin
      if (!mem_ras_n) hi_cnt <= '0;
      else if (hi_cnt < CW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
      if (!ref_pend) ref_wait <= '0;
      else if (ref_wait != '1) ref_wait <= ref_wait + 1'b1;
    end
  end

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n) !mem_cas_n |-> !mem_ras_n); // R3
  AST_ROW_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_ras_n) |-> $stable(mem_addr)); // R2
  AST_COL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_cas_n) |-> $stable(mem_addr)); // R3
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n) ($fell(mem_cas_n) && !mem_we_n) |-> ($past(mem_we_n) == 1'b0 && mem_dq_oe)); // R5
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_ras_n) |-> hi_cnt >= CW'(T_RP)); // R4
  AST_REFRESH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) ref_pend |-> !req_ready); // R10
  AST_REFRESH_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ref_wait <= CW'(MAX_WAIT)); // R9
endmodule

// File: tb/tb_dram_ctrl.sv
module tb_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_RAS = 3, RD_LAT = 2, REF_INTERVAL = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [3:0] mem_addr;

  dram_ctrl #(.ADDR_W(8), .DATA_W(8), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
              .T_RAS(T_RAS), .RD_LAT(RD_LAT), .REF_INTERVAL(REF_INTERVAL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [7:0] cells [256];
  logic [7:0] expv  [256];
  logic [3:0] m_row = '0, cas_row = '0, cas_col = '0, exp_ref = '0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, cas_in = 1'b0;
  int ras_fall_c = 0, ras_rise_c = -100, cas_fall_c = 0, last_ref_c = 0;
  int ras_falls = 0, ncas = 0, nref = 0;

  assign mem_dq_in = !mem_cas_n ? cells[{cas_row, cas_col}] : 8'h00;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      finish_up();
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (p_ras && !mem_ras_n) begin
      ras_falls++;
      chk("R4 precharge width", int'(cyc - ras_rise_c >= T_RP), 1);
      ras_fall_c = cyc; m_row = mem_addr; cas_in = 1'b0;
    end
    if (!p_ras && mem_ras_n) begin
      ras_rise_c = cyc;
      if (!cas_in) begin
        chk("R9 refresh row", int'(m_row), int'(exp_ref));
        chk("R9 refresh width", cyc - ras_fall_c, T_RAS);
        chk("R9 refresh spacing", int'(ras_fall_c - last_ref_c <= REF_INTERVAL + 16), 1);
        exp_ref = exp_ref + 4'd1; last_ref_c = ras_fall_c; nref++;
      end
    end
    if (p_cas && !mem_cas_n) begin
      chk("R3 cas inside ras", int'(mem_ras_n), 0);
      if (!cas_in) chk("R4 row to column", cyc - ras_fall_c, T_RCD + 1);
      cas_in = 1'b1; cas_row = m_row; cas_col = mem_addr; cas_fall_c = cyc;
      if (!mem_we_n) begin
        chk("R5 we setup", int'(p_we), 0);
        chk("R5 dq enable", int'(mem_dq_oe), 1);
        cells[{m_row, mem_addr}] = mem_dq_out;
      end
      ncas++;
    end
    if (!p_cas && mem_cas_n) chk("R4 cas width", cyc - cas_fall_c, T_CAS);
    p_ras = mem_ras_n; p_cas = mem_cas_n; p_we = mem_we_n;
  end

  task automatic do_req(input bit wr, input logic [7:0] a, input logic [7:0] d);
    int n0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    n0 = ncas;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy after accept", int'(req_ready), 0);
    if (wr) begin
      expv[a] = d;
      while (ncas == n0) @(negedge clk);
      chk("R5 written value", int'(cells[a]), int'(d));
    end else begin
      while (!rsp_valid) @(negedge clk);
      chk("R6 read data", int'(rsp_rdata), int'(expv[a]));
    end
    chk("R2 row half", int'(cas_row), int'(a[7:4]));
    chk("R3 column half", int'(cas_col), int'(a[3:0]));
  endtask

  initial begin
    int f, r0, rf0;
    for (int i = 0; i < 256; i++) begin cells[i] = 8'h00; expv[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ras high", int'(mem_ras_n), 1);
    chk("R1 cas high", int'(mem_cas_n), 1);
    chk("R1 we high", int'(mem_we_n), 1);
    chk("R1 oe low", int'(mem_dq_oe), 0);
    chk("R1 rsp idle", int'(rsp_valid), 0);
    chk("R1 ready", int'(req_ready), 1);

    for (int a = 0; a < 256; a++) do_req(1'b1, 8'(a), 8'(a * 7 + 3));
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 16; r++) do_req(1'b0, 8'(r * 16 + c), 8'h00);

    r0 = nref;
    while (nref == r0) @(negedge clk);
    f = ras_falls; do_req(1'b0, 8'h35, 8'h00);
    chk("R8 open from idle", ras_falls - f, 1);
    f = ras_falls; do_req(1'b1, 8'h3A, 8'h5C);
    chk("R7 write hit", ras_falls - f, 0);
    f = ras_falls; do_req(1'b0, 8'h3A, 8'h00);
    chk("R7 read hit", ras_falls - f, 0);
    f = ras_falls; do_req(1'b0, 8'h72, 8'h00);
    chk("R8 miss reopen", ras_falls - f, 1);

    r0 = nref; rf0 = ras_falls;
    for (int i = 0; i < 100; i++) do_req(1'b0, 8'(8'h60 + (i % 16)), 8'h00);
    chk("R10 refresh under load", int'(nref - r0 >= 4), 1);
    f = (ras_falls - rf0) - (nref - r0);
    chk("R10 page reopened", int'(f == nref - r0 || f == nref - r0 + 1), 1);
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule